// File: doc/BRIEF.md
# Hexagon Motion Search Engine

This block finds an integer-pel motion vector for one square block of luma samples. A start command gives it a predicted vector, a block size code and the block's position in the picture. From the predicted point it walks a six-point hexagon across the reference picture, scoring every candidate by its sum of absolute differences (SAD). The walk stops when the centre point scores best or when a round limit is reached. A four-point cross around the final centre then refines the result. The block reports the winning vector and its SAD together with a one-cycle done pulse.

Samples are fetched through two synchronous row-read ports, one for the current block and one for the reference picture. Each cycle, one current row and one reference row arrive and feed a row-wide array of processing elements. Every element uses the same broadcast reference row and takes the sample at its own lane position. Before differencing, each element drops the two least significant bits of both samples, so all SAD arithmetic works on 6-bit values.

Top module: `hexme_top`

## Requirements
- R1: `start` is accepted only while `busy` is low. A `start` raised while a search runs has no effect on that search's result. `busy` rises in the cycle after an accepted start.
- R2: A candidate's SAD is the sum, over every sample of the block, of |(cur >> 2) − (ref >> 2)| on 8-bit samples. It is held in a 16-bit accumulator that never wraps for a 32x32 block. Samples that differ only in their two low bits contribute zero.
- R3: `sizeCode` selects the block edge: 0 gives 8, 1 gives 16, and 2 or 3 give 32. Only that many lanes and rows enter the SAD.
- R4: The search starts at the predicted vector, with each component clamped to [−SRCH_R, +SRCH_R]. That point is scored first.
- R5: Each hexagon round scores the points at offsets (−2,0), (+2,0), (−1,−2), (+1,−2), (−1,+2), (+1,+2) from the centre, in that order, and the centre moves to the best point. The hexagon phase ends when the best point is the centre, or after 16 rounds, in which case the centre still moves to that round's best point first.
- R6: The refinement step scores (−1,0), (+1,0), (0,−1), (0,+1) around the final centre, in that order, and reports the best of these and the centre.
- R7: A candidate replaces the current best only when its SAD is strictly lower, so among equal SADs the point scored first is reported.
- R8: A candidate whose vector has a component outside [−SRCH_R, +SRCH_R] is never read and never reported.
- R9: In every hexagon round after the first, a candidate that equals the previous round's centre or one of that centre's six hexagon points is not scored again.
- R10: Every scored candidate costs exactly N reads on each port, for an N-row block. Row r of candidate (mx,my) reads reference row y = posY+my+r starting at x = posX+mx, and lane i uses the sample at x+i. Read data arrives in the cycle after the read strobe.
- R11: `done` is high for exactly one cycle, and `busy` is low in that cycle. `bestMvX`, `bestMvY` and `bestSad` keep their values until the next accepted start. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (honoured when idle) |
| sizeCode | input | 2 | Block edge select |
| predMvX | input | MV_W | Predicted vector, horizontal, two's complement |
| predMvY | input | MV_W | Predicted vector, vertical, two's complement |
| blkPosX | input | POS_W | Block left column |
| blkPosY | input | POS_W | Block top row |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| bestMvX | output | MV_W | Winning vector, horizontal |
| bestMvY | output | MV_W | Winning vector, vertical |
| bestSad | output | SAD_W | SAD of the winning vector |
| curRdEn | output | 1 | Current-block row read strobe |
| curRdRow | output | log2(MAX_BLK) | Current-block row index |
| curRowData | input | MAX_BLK*8 | Current row, lane i in bits 8i+7:8i |
| refRdEn | output | 1 | Reference row read strobe |
| refRdX | output | POS_W+2 | Reference row start column, signed |
| refRdY | output | POS_W+2 | Reference row, signed |
| refRowData | input | MAX_BLK*8 | Reference row, lane i at column refRdX+i |

## Verification
Read data must come back one cycle after its strobe, and the bench's memory model updates its row buses on that same edge. A candidate's SAD is final two cycles after its last row read. The vector and SAD are due in the cycle `done` is high, so the bench polls on falling edges until it sees `done`, then compares them with its own search model. It checks the cycle after that for `done` low, and three cycles later for unchanged outputs. Read strobes are counted and range-checked on every rising edge, and the count is compared at `done` with N times the number of candidates the model scored.

// File: rtl/hexme_pkg.sv
package hexme_pkg;

  typedef struct packed {
    logic accClr;
    logic accEn;
  } dpCtl_t;

  typedef enum logic [2:0] {ST_IDLE, ST_PICK, ST_ISSUE, ST_WAIT, ST_CMP} state_t;
  typedef enum logic {PH_HEX, PH_SMALL} phase_t;

  // Hexagon points 1..6; index 0 is the centre itself.
  function automatic logic signed [2:0] hexOffX(input logic [2:0] idx);
    case (idx)
      3'd1: return -3'sd2;
      3'd2: return 3'sd2;
      3'd3, 3'd5: return -3'sd1;
      3'd4, 3'd6: return 3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

  function automatic logic signed [2:0] hexOffY(input logic [2:0] idx);
    case (idx)
      3'd3, 3'd4: return -3'sd2;
      3'd5, 3'd6: return 3'sd2;
      default: return 3'sd0;
    endcase
  endfunction

  // Cross points 1..4; index 0 is the centre itself.
  function automatic logic signed [2:0] crossOffX(input logic [2:0] idx);
    case (idx)
      3'd1: return -3'sd1;
      3'd2: return 3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

  function automatic logic signed [2:0] crossOffY(input logic [2:0] idx);
    case (idx)
      3'd3: return -3'sd1;
      3'd4: return 3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

endpackage

// File: rtl/hexme_dp.sv
module hexme_dp
  import hexme_pkg::*;
#(
  parameter int MAX_BLK   = 32,
  parameter int PIX_W     = 8,
  parameter int DROP_BITS = 2,
  parameter int SAD_W     = 16,
  localparam int CNT_W    = $clog2(MAX_BLK) + 1,
  localparam int KEEP_W   = PIX_W - DROP_BITS,
  localparam int SUM_W    = KEEP_W + $clog2(MAX_BLK) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dpCtl_t                   dpCtl,
  input  logic [CNT_W-1:0]         laneCnt,
  input  logic [MAX_BLK*PIX_W-1:0] curRow,
  input  logic [MAX_BLK*PIX_W-1:0] refRow,
  output logic [SAD_W-1:0]         candSad
);

  logic [KEEP_W-1:0] laneAbs [MAX_BLK];
  logic [SUM_W-1:0]  rowSum;

  // One processing element per lane; all share the broadcast reference row.
  for (genvar g = 0; g < MAX_BLK; g++) begin : g_pe
    localparam int unsigned LANE = g;
    logic [PIX_W-1:0]  curPix, refPix;
    logic [KEEP_W-1:0] curKeep, refKeep;
    logic              laneOn;
    assign curPix  = curRow[g*PIX_W +: PIX_W];
    assign refPix  = refRow[g*PIX_W +: PIX_W];
    assign curKeep = KEEP_W'(curPix >> DROP_BITS);
    assign refKeep = KEEP_W'(refPix >> DROP_BITS);
    assign laneOn  = laneCnt > LANE[CNT_W-1:0];
    always_comb begin
      if (!laneOn)                laneAbs[g] = '0;
      else if (curKeep > refKeep) laneAbs[g] = curKeep - refKeep;
      else                        laneAbs[g] = refKeep - curKeep;
    end
  end

  always_comb begin
    rowSum = '0;
    for (int i = 0; i < MAX_BLK; i++) rowSum = rowSum + SUM_W'(laneAbs[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)               candSad <= '0;
    else if (dpCtl.accClr) candSad <= '0;
    else if (dpCtl.accEn)  candSad <= candSad + SAD_W'(rowSum);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (dpCtl.accEn && !dpCtl.accClr) |=> (candSad >= $past(candSad))); // R2

endmodule

// File: rtl/hexme_ctrl.sv
module hexme_ctrl
  import hexme_pkg::*;
#(
  parameter int MAX_BLK  = 32,
  parameter int MIN_BLK  = 8,
  parameter int MV_W     = 8,
  parameter int POS_W    = 12,
  parameter int SAD_W    = 16,
  parameter int SRCH_R   = 8,
  parameter int ITER_MAX = 16,
  localparam int ROW_W   = $clog2(MAX_BLK),
  localparam int CNT_W   = ROW_W + 1,
  localparam int VEC_W   = MV_W + 1,
  localparam int RND_W   = $clog2(ITER_MAX) + 1,
  localparam int ADR_W   = POS_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        sizeCode,
  input  logic [MV_W-1:0]   predMvX,
  input  logic [MV_W-1:0]   predMvY,
  input  logic [POS_W-1:0]  blkPosX,
  input  logic [POS_W-1:0]  blkPosY,
  input  logic [SAD_W-1:0]  candSad,
  output logic              busy,
  output logic              done,
  output logic [MV_W-1:0]   bestMvX,
  output logic [MV_W-1:0]   bestMvY,
  output logic [SAD_W-1:0]  bestSad,
  output logic              rdEn,
  output logic [ROW_W-1:0]  rdRow,
  output logic [ADR_W-1:0]  refRdX,
  output logic [ADR_W-1:0]  refRdY,
  output logic [CNT_W-1:0]  laneCnt,
  output dpCtl_t            dpCtl
);

  localparam logic signed [VEC_W-1:0] RNG = VEC_W'(SRCH_R);
  localparam logic signed [VEC_W-1:0] V1  = VEC_W'(1);
  localparam logic signed [VEC_W-1:0] V2  = VEC_W'(2);

  state_t state;
  phase_t phase;
  logic [2:0]              candIdx, lastIdx;
  logic [RND_W-1:0]        round;
  logic signed [VEC_W-1:0] cenX, cenY, prevX, prevY, bestX, bestY;
  logic signed [VEC_W-1:0] candX, candY, dX, dY, predX, predY, startX, startY;
  logic [SAD_W-1:0]        bestAcc;
  logic                    bestValid, rdEnQ;
  logic [ROW_W-1:0]        row;
  logic [CNT_W-1:0]        blkN, dimSel;
  logic [POS_W-1:0]        posX, posY;
  logic                    inRange, revisit, candSkip, roundEnd;
  int                      dimFull;

  // Candidate under consideration.
  always_comb begin
    if (phase == PH_HEX) begin
      candX   = cenX + VEC_W'(hexOffX(candIdx));
      candY   = cenY + VEC_W'(hexOffY(candIdx));
      lastIdx = 3'd6;
    end else begin
      candX   = cenX + VEC_W'(crossOffX(candIdx));
      candY   = cenY + VEC_W'(crossOffY(candIdx));
      lastIdx = 3'd4;
    end
    dX = candX - prevX;
    dY = candY - prevY;
    revisit  = (dX == '0 && dY == '0)
            || ((dX == V2 || dX == -V2) && dY == '0)
            || ((dX == V1 || dX == -V1) && (dY == V2 || dY == -V2));
    inRange  = candX >= -RNG && candX <= RNG && candY >= -RNG && candY <= RNG;
    roundEnd = candIdx > lastIdx;
    candSkip = !inRange
            || (candIdx == 3'd0 && !(phase == PH_HEX && round == '0))
            || (phase == PH_HEX && round != '0 && revisit);
  end

  // Start-time decode: block edge and clamped predictor.
  always_comb begin
    dimFull = MIN_BLK << sizeCode;
    dimSel  = (dimFull > MAX_BLK) ? CNT_W'(MAX_BLK) : CNT_W'(dimFull);
    predX   = VEC_W'($signed(predMvX));
    predY   = VEC_W'($signed(predMvY));
    startX  = (predX > RNG) ? RNG : (predX < -RNG) ? -RNG : predX;
    startY  = (predY > RNG) ? RNG : (predY < -RNG) ? -RNG : predY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;   phase <= PH_HEX;
      candIdx <= '0;      round <= '0;
      cenX <= '0;  cenY <= '0;  prevX <= '0; prevY <= '0;
      bestX <= '0; bestY <= '0; bestAcc <= '0; bestValid <= 1'b0;
      row <= '0;   blkN <= '0;  posX <= '0;  posY <= '0;
      rdEnQ <= 1'b0; done <= 1'b0;
      bestMvX <= '0; bestMvY <= '0; bestSad <= '0;
    end else begin
      done  <= 1'b0;
      rdEnQ <= (state == ST_ISSUE);
      unique case (state)
        ST_IDLE: if (start) begin
          posX <= blkPosX; posY <= blkPosY; blkN <= dimSel;
          cenX <= startX;  cenY <= startY;
          phase <= PH_HEX; round <= '0; candIdx <= '0; bestValid <= 1'b0;
          state <= ST_PICK;
        end
        ST_PICK: begin
          if (roundEnd) begin
            if (phase == PH_HEX) begin
              prevX <= cenX; prevY <= cenY;
              cenX <= bestX; cenY <= bestY;
              candIdx <= '0;
              if ((bestX == cenX && bestY == cenY) || round == RND_W'(ITER_MAX - 1))
                phase <= PH_SMALL;
              else
                round <= round + 1'b1;
            end else begin
              state   <= ST_IDLE;
              done    <= 1'b1;
              bestMvX <= bestX[MV_W-1:0];
              bestMvY <= bestY[MV_W-1:0];
              bestSad <= bestAcc;
            end
          end else if (candSkip) begin
            candIdx <= candIdx + 1'b1;
          end else begin
            row   <= '0;
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          row <= row + 1'b1;
          if ({1'b0, row} == blkN - 1'b1) state <= ST_WAIT;
        end
        ST_WAIT: state <= ST_CMP;
        ST_CMP: begin
          if (!bestValid || candSad < bestAcc) begin
            bestX <= candX; bestY <= candY; bestAcc <= candSad; bestValid <= 1'b1;
          end
          candIdx <= candIdx + 1'b1;
          state   <= ST_PICK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state != ST_IDLE);
  assign rdEn         = (state == ST_ISSUE);
  assign rdRow        = row;
  assign laneCnt      = blkN;
  assign refRdX       = $signed({2'b00, posX}) + ADR_W'(candX);
  assign refRdY       = $signed({2'b00, posY}) + ADR_W'(candY) + $signed(ADR_W'(row));
  assign dpCtl.accEn  = rdEnQ;
  assign dpCtl.accClr = (state == ST_PICK) && !roundEnd && !candSkip;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(bestMvX) && $stable(bestMvY) && $stable(bestSad))); // R11
  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> (candX >= -RNG && candX <= RNG && candY >= -RNG && candY <= RNG)); // R8
  AST_RESULT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (VEC_W'($signed(bestMvX)) <= RNG && VEC_W'($signed(bestMvX)) >= -RNG
           && VEC_W'($signed(bestMvY)) <= RNG && VEC_W'($signed(bestMvY)) >= -RNG)); // R8

endmodule

// File: rtl/hexme_top.sv
module hexme_top #(
  parameter int MAX_BLK   = 32,
  parameter int MIN_BLK   = 8,
  parameter int DROP_BITS = 2,
  parameter int SAD_W     = 16,
  parameter int MV_W      = 8,
  parameter int POS_W     = 12,
  parameter int SRCH_R    = 8,
  parameter int ITER_MAX  = 16,
  localparam int PIX_W    = 8,
  localparam int ROW_W    = $clog2(MAX_BLK),
  localparam int CNT_W    = ROW_W + 1,
  localparam int ADR_W    = POS_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [1:0]               sizeCode,
  input  logic [MV_W-1:0]          predMvX,
  input  logic [MV_W-1:0]          predMvY,
  input  logic [POS_W-1:0]         blkPosX,
  input  logic [POS_W-1:0]         blkPosY,
  output logic                     busy,
  output logic                     done,
  output logic [MV_W-1:0]          bestMvX,
  output logic [MV_W-1:0]          bestMvY,
  output logic [SAD_W-1:0]         bestSad,
  output logic                     curRdEn,
  output logic [ROW_W-1:0]         curRdRow,
  input  logic [MAX_BLK*PIX_W-1:0] curRowData,
  output logic                     refRdEn,
  output logic [ADR_W-1:0]         refRdX,
  output logic [ADR_W-1:0]         refRdY,
  input  logic [MAX_BLK*PIX_W-1:0] refRowData
);

  hexme_pkg::dpCtl_t dpCtl;
  logic [SAD_W-1:0]  candSad;
  logic [CNT_W-1:0]  laneCnt;
  logic              rdEn;

  hexme_ctrl #(
    .MAX_BLK(MAX_BLK), .MIN_BLK(MIN_BLK), .MV_W(MV_W), .POS_W(POS_W),
    .SAD_W(SAD_W), .SRCH_R(SRCH_R), .ITER_MAX(ITER_MAX)
  ) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .sizeCode(sizeCode),
    .predMvX(predMvX), .predMvY(predMvY), .blkPosX(blkPosX), .blkPosY(blkPosY),
    .candSad(candSad), .busy(busy), .done(done),
    .bestMvX(bestMvX), .bestMvY(bestMvY), .bestSad(bestSad),
    .rdEn(rdEn), .rdRow(curRdRow), .refRdX(refRdX), .refRdY(refRdY),
    .laneCnt(laneCnt), .dpCtl(dpCtl)
  );

  hexme_dp #(
    .MAX_BLK(MAX_BLK), .PIX_W(PIX_W), .DROP_BITS(DROP_BITS), .SAD_W(SAD_W)
  ) dp_i (
    .clk(clk), .rst(rst), .dpCtl(dpCtl), .laneCnt(laneCnt),
    .curRow(curRowData), .refRow(refRowData), .candSad(candSad)
  );

  assign curRdEn = rdEn;
  assign refRdEn = rdEn;

endmodule

// File: tb/hexme_top_tb_top.sv
`timescale 1ns/1ps
module hexme_top_tb_top;

  localparam int MAX_BLK = 32;
  localparam int SRCH_R  = 8;
  localparam int MV_W    = 8;
  localparam int POS_W   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] sizeCode = '0;
  logic [MV_W-1:0] predMvX = '0, predMvY = '0;
  logic [POS_W-1:0] blkPosX = '0, blkPosY = '0;
  logic busy, done, curRdEn, refRdEn;
  logic [MV_W-1:0] bestMvX, bestMvY;
  logic [15:0] bestSad;
  logic [4:0] curRdRow;
  logic [POS_W+1:0] refRdX, refRdY;
  logic [MAX_BLK*8-1:0] curRowData = '0, refRowData = '0;

  always #2.5 clk = ~clk;

  hexme_top dut_i (
    .clk(clk), .rst(rst), .start(start), .sizeCode(sizeCode),
    .predMvX(predMvX), .predMvY(predMvY), .blkPosX(blkPosX), .blkPosY(blkPosY),
    .busy(busy), .done(done), .bestMvX(bestMvX), .bestMvY(bestMvY), .bestSad(bestSad),
    .curRdEn(curRdEn), .curRdRow(curRdRow), .curRowData(curRowData),
    .refRdEn(refRdEn), .refRdX(refRdX), .refRdY(refRdY), .refRowData(refRowData)
  );

  int vectors = 0, miscompares = 0;
  int gPosX, gPosY, gTx, gTy, gMode, gFlatCur;
  int refReads, rangeErrs, portSkew;

  function automatic int refPix(int x, int y);
    if (gMode == 1) return 100;
    return (((x*x + 3*y*y + 5*x*y) >>> 3) ^ (x*11 + y*7)) & 255;
  endfunction

  function automatic int curPix(int i, int r);
    if (gMode == 1) return gFlatCur;
    return (refPix(gPosX + gTx + i, gPosY + gTy + r) + ((i*3 + r*5) % 4)) & 255;
  endfunction

  // Memory model: row data one cycle after the strobe (R10).
  always @(posedge clk) begin
    if (curRdEn)
      for (int i = 0; i < MAX_BLK; i++) curRowData[i*8 +: 8] <= 8'(curPix(i, int'(curRdRow)));
    if (refRdEn) begin
      for (int i = 0; i < MAX_BLK; i++)
        refRowData[i*8 +: 8] <= 8'(refPix(int'($signed(refRdX)) + i, int'($signed(refRdY))));
      refReads++;
      if (int'($signed(refRdX)) - gPosX > SRCH_R || int'($signed(refRdX)) - gPosX < -SRCH_R)
        rangeErrs++;
    end
    if (curRdEn != refRdEn) portSkew++;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sadAt(int mx, int my, int n);
    int s = 0;
    for (int r = 0; r < n; r++)
      for (int i = 0; i < n; i++) begin
        int d = (curPix(i, r) >> 2) - (refPix(gPosX + mx + i, gPosY + my + r) >> 2);
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  function automatic bit inR(int x, int y);
    return x >= -SRCH_R && x <= SRCH_R && y >= -SRCH_R && y <= SRCH_R;
  endfunction

  function automatic bit onHex(int dx, int dy);
    return (dx == 0 && dy == 0) || ((dx == 2 || dx == -2) && dy == 0)
        || ((dx == 1 || dx == -1) && (dy == 2 || dy == -2));
  endfunction

  task automatic model(input int px, input int py, input int n,
                       output int ex, output int ey, output int es, output int cnt);
    int hx[6] = '{-2, 2, -1, 1, -1, 1};
    int hy[6] = '{0, 0, -2, -2, 2, 2};
    int sx[4] = '{-1, 1, 0, 0};
    int sy[4] = '{0, 0, -1, 1};
    int cx, cy, prx, pry, bx, by, bs, s;
    cx = (px > SRCH_R) ? SRCH_R : (px < -SRCH_R) ? -SRCH_R : px;
    cy = (py > SRCH_R) ? SRCH_R : (py < -SRCH_R) ? -SRCH_R : py;
    bx = cx; by = cy; bs = sadAt(cx, cy, n); cnt = 1; prx = 0; pry = 0;
    for (int rnd = 0; rnd < 16; rnd++) begin
      bit moved;
      for (int k = 0; k < 6; k++) begin
        int x = cx + hx[k], y = cy + hy[k];
        if (!inR(x, y)) continue;
        if (rnd > 0 && onHex(x - prx, y - pry)) continue;
        s = sadAt(x, y, n); cnt++;
        if (s < bs) begin bs = s; bx = x; by = y; end
      end
      moved = (bx != cx) || (by != cy);
      prx = cx; pry = cy; cx = bx; cy = by;
      if (!moved) break;
    end
    for (int k = 0; k < 4; k++) begin
      int x = cx + sx[k], y = cy + sy[k];
      if (!inR(x, y)) continue;
      s = sadAt(x, y, n); cnt++;
      if (s < bs) begin bs = s; bx = x; by = y; end
    end
    ex = bx; ey = by; es = bs;
  endtask

  task automatic runSearch(input string req, input int code, input int px, input int py,
                           input int posx, input int posy, input int tx, input int ty,
                           input int mode, input int flatCur, input bit interfere);
    int n, ex, ey, es, cnt, waitCyc;
    int hx0, hy0, hs0;
    gPosX = posx; gPosY = posy; gTx = tx; gTy = ty; gMode = mode; gFlatCur = flatCur;
    n = (code == 0) ? 8 : (code == 1) ? 16 : 32;
    model(px, py, n, ex, ey, es, cnt);
    @(negedge clk);
    refReads = 0; rangeErrs = 0; portSkew = 0;
    start = 1'b1; sizeCode = 2'(code);
    predMvX = MV_W'(px); predMvY = MV_W'(py);
    blkPosX = POS_W'(posx); blkPosY = POS_W'(posy);
    @(negedge clk);
    start = 1'b0;
    chk({req, "/R1 busy after start"}, int'(busy), 1);
    if (interfere) begin
      repeat (5) @(negedge clk);
      start = 1'b1; sizeCode = 2'(3 - code); predMvX = MV_W'(-px); predMvY = MV_W'(3);
      blkPosX = POS_W'(posx + 7);
      @(negedge clk);
      start = 1'b0;
    end
    waitCyc = 0;
    while (!done && waitCyc < 30000) begin @(negedge clk); waitCyc++; end
    chk({req, "/done seen"}, int'(done), 1);
    chk({req, "/R11 busy low at done"}, int'(busy), 0);
    chk({req, "/mvX"}, int'($signed(bestMvX)), ex);
    chk({req, "/mvY"}, int'($signed(bestMvY)), ey);
    chk({req, "/sad"}, int'(bestSad), es);
    chk({req, "/R10 R9 reference reads"}, refReads, cnt * n);
    chk({req, "/R8 reads in range"}, rangeErrs, 0);
    chk({req, "/R10 port strobes paired"}, portSkew, 0);
    hx0 = int'($signed(bestMvX)); hy0 = int'($signed(bestMvY)); hs0 = int'(bestSad);
    @(negedge clk);
    chk({req, "/R11 done one cycle"}, int'(done), 0);
    repeat (3) @(negedge clk);
    chk({req, "/R11 held"}, int'($signed(bestMvX)) + 1000 * int'($signed(bestMvY)) + int'(bestSad) * 7,
        hx0 + 1000 * hy0 + hs0 * 7);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset sad", int'(bestSad), 0);
    chk("R11 reset read strobe", int'(refRdEn), 0);

    // R7 ties: flat picture keeps the predictor; R2 low bits ignored
    runSearch("R7 tie keeps centre", 0, 3, -2, 60, 60, 0, 0, 1, 103, 1'b0);
    chk("R7 flat sad zero (R2 low bits)", int'(bestSad), 0);
    // R3 per-size SAD on a one-step difference
    runSearch("R3 size8", 0, 0, 0, 50, 50, 0, 0, 1, 104, 1'b0);
    chk("R3 8x8 count", int'(bestSad), 64);
    runSearch("R3 size16", 1, 1, 1, 50, 50, 0, 0, 1, 104, 1'b0);
    chk("R3 16x16 count", int'(bestSad), 256);
    runSearch("R3 size32", 2, 0, 0, 50, 50, 0, 0, 1, 104, 1'b0);
    chk("R3 32x32 count", int'(bestSad), 1024);
    runSearch("R3 code3", 3, 0, 0, 50, 50, 0, 0, 1, 104, 1'b0);
    chk("R3 code3 count", int'(bestSad), 1024);
    // R2 worst case 32x32 with full-scale difference
    runSearch("R2 no wrap", 2, 0, 0, 50, 50, 0, 0, 1, 255, 1'b0);
    chk("R2 max sad", int'(bestSad), 1024 * 38);
    // R4 R8 clamp at the corner of the range
    runSearch("R4 clamp", 0, 100, -100, 80, 80, 0, 0, 1, 100, 1'b0);
    chk("R4 clamped x", int'($signed(bestMvX)), SRCH_R);
    chk("R8 corner reads", refReads, 5 * 8);
    // R1 start while busy is ignored
    runSearch("R1 ignore", 0, 2, 1, 100, 90, 5, -4, 0, 0, 1'b1);
    // R5 R6 R9 search trajectories on a textured picture
    runSearch("R5 R6 directed", 1, -6, 6, 120, 70, 7, -7, 0, 0, 1'b0);
    for (int t = 0; t < 14; t++) begin
      int code = ($urandom % 4 == 0) ? 2 : int'($urandom % 2);
      runSearch("R5 R6 R9 random", code,
                int'($urandom % 21) - 10, int'($urandom % 21) - 10,
                40 + int'($urandom % 200), 40 + int'($urandom % 200),
                int'($urandom % 17) - 8, int'($urandom % 17) - 8, 0, 0, 1'b0);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule